// File: doc/BRIEF.md
# Table Section Filter with CRC Check

This block reassembles table sections from the payload bytes of packets that carry system data. Bytes arrive one per transfer on a valid/ready input. Each transfer also carries a flag for the first payload byte of a packet and, with that byte, the packet's payload-unit-start flag. When payload-unit-start is set, that first byte is a pointer giving how many bytes to skip before a new section begins. A section may begin mid-packet, may run on through later packets that lack payload-unit-start, and may share a packet with further sections when the multi-section control allows it. A table-id byte of 0xFF in the place of a section start means the rest of the payload is stuffing.

The block reads the 12-bit section length from the header. It compares the leading header bytes, skipping the two length bytes, against a programmable value and mask. It runs a CRC-32 over every section byte. Each finished or abandoned section gets one verdict on a result strobe: accepted, filter miss, CRC failure or cut short. Every section byte is forwarded on a registered valid/ready output stream with first/last markers, so a downstream writer can keep or discard the section once its verdict arrives.

Top module: `sf_section_filter`

## Requirements
- R1: After reset, out_valid and res_valid are low, and all bytes are ignored until a packet whose first payload byte has in_pusi=1 arrives.
- R2: A transfer with in_first=1 and in_pusi=1 is a pointer byte p. It is never forwarded. The next p transferred bytes are skipped, and the byte after them is taken as a section start.
- R3: The section length L is {byte1[3:0], byte2} (byte 0 is the table id), and the section is L+3 bytes long. The verdict for a section appears as a one-cycle res_valid pulse in the cycle after its last byte is transferred.
- R4: Bytes of packets with in_first=1 and in_pusi=0 continue a section that is in progress, so a section and its header may be split over several packets.
- R5: Header byte 0 is compared with flt_value/flt_mask lane 0, and header byte k (3 <= k <= 7) with lane k-2. Lane i is bits [8i+7:8i]. A mask bit of 1 requires equality, and a mask bit of 0 ignores that bit. Any required bit that differs gives res_code 1 (miss).
- R6: A section that ends before header byte 7 is reached (fewer than 8 bytes) gives res_code 1 (miss).
- R7: The CRC is CRC-32, polynomial 0x04C11DB7, starting at all ones with no final inversion, run over all section bytes including the CRC field. A nonzero result gives res_code 2. res_code 0 means filter pass and a zero CRC. Miss takes priority over CRC failure.
- R8: A pointer byte that arrives while a section is in progress drops that section and reports res_code 3 (short) in the following cycle. Assembly then restarts at the pointer offset.
- R9: After a section ends, the next byte of the same packet starts a new section only if cfg_multi=1 and the packet has payload-unit-start. Otherwise bytes are ignored until the next pointer byte. A start byte of 0xFF also causes bytes to be ignored until the next pointer byte.
- R10: Each section byte appears on out_data in the cycle after its transfer, with out_first on the table-id byte and out_last on the final byte. Pointer, skipped and stuffing bytes are never forwarded.
- R11: in_ready is low while out_valid=1 and out_ready=0. A stalled output holds its data and markers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Block takes the offered byte |
| in_data | input | 8 | Payload byte |
| in_first | input | 1 | Byte is the first payload byte of its packet |
| in_pusi | input | 1 | Payload-unit-start of the packet, valid with in_first |
| cfg_multi | input | 1 | Allow several sections in one packet |
| flt_value | input | 48 | Filter compare bytes, one lane per compared header byte |
| flt_mask | input | 48 | Filter mask, 1 = bit must match |
| out_valid | output | 1 | Forwarded section byte valid |
| out_ready | input | 1 | Downstream takes the forwarded byte |
| out_data | output | 8 | Forwarded section byte |
| out_first | output | 1 | Forwarded byte is a table id |
| out_last | output | 1 | Forwarded byte ends its section |
| res_valid | output | 1 | Section verdict strobe |
| res_code | output | 2 | 0 accepted, 1 filter miss, 2 CRC failure, 3 short |

## Verification
Forwarded bytes and verdicts are both due exactly one cycle after the input transfer that produces them. in_ready follows out_valid and out_ready within the same cycle. The bench drives at the falling edge and checks in_ready shortly afterwards. It updates its behavioural model only when that transfer really takes place, and compares the model's prediction with the outputs at the next falling edge, so every cycle is checked with a backpressure pattern either on or off. Each scenario then also compares the sequence of verdicts it collected against a hand-written list.

// File: rtl/sf_pkg.sv
package sf_pkg;

   typedef enum logic [1:0] {
      RES_OK    = 2'd0,
      RES_MISS  = 2'd1,
      RES_CRC   = 2'd2,
      RES_SHORT = 2'd3
   } res_e;

   typedef enum logic [1:0] {
      ST_WAIT,
      ST_SKIP,
      ST_START,
      ST_BODY
   } st_e;

   localparam logic [7:0] STUFF_BYTE = 8'hFF;

   // One byte of a non-reflected CRC, most significant bit first.
   function automatic logic [31:0] crc_step(input logic [31:0] c,
                                            input logic [7:0]  d,
                                            input logic [31:0] poly);
      logic [31:0] r;
      logic        fb;
      r = c;
      for (int i = 7; i >= 0; i--) begin
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0} ^ (fb ? poly : 32'h0);
      end
      return r;
   endfunction

endpackage

// File: rtl/sf_crc_acc.sv
module sf_crc_acc #(
   parameter logic [31:0] POLY = 32'h04C11DB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        step,
   input  logic [7:0]  data,
   output logic [31:0] crc_next
);
   logic [31:0] crc_q;
   logic [31:0] crc_base;

   assign crc_base = start ? 32'hFFFF_FFFF : crc_q;
   assign crc_next = sf_pkg::crc_step(crc_base, data, POLY);

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
      else if (step) crc_q <= crc_next;
   end
endmodule

// File: rtl/sf_hdr_match.sv
module sf_hdr_match #(
   parameter int HDR_BYTES = 8,
   parameter int IDX_W     = 13,
   localparam int LANES    = HDR_BYTES - 2,
   localparam int FLT_W    = LANES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   input  logic [FLT_W-1:0] flt_value,
   input  logic [FLT_W-1:0] flt_mask,
   output logic             miss_now
);
   logic [LANES-1:0] lane_bad;
   logic             acc_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int POS = (i == 0) ? 0 : i + 2;
      assign lane_bad[i] = (idx == IDX_W'(POS)) &&
                           (|((data ^ flt_value[8*i +: 8]) & flt_mask[8*i +: 8]));
   end

   assign miss_now = (start ? 1'b0 : acc_q) | (|lane_bad);

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= 1'b0;
      else if (step) acc_q <= miss_now;
   end
endmodule

// File: rtl/sf_section_filter.sv
module sf_section_filter #(
   parameter int          HDR_BYTES = 8,
   parameter int          LEN_BITS  = 12,
   parameter logic [31:0] CRC_POLY  = 32'h04C11DB7,
   localparam int         FLT_W     = (HDR_BYTES - 2) * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_first,
   input  logic             in_pusi,
   input  logic             cfg_multi,
   input  logic [FLT_W-1:0] flt_value,
   input  logic [FLT_W-1:0] flt_mask,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_first,
   output logic             out_last,
   output logic             res_valid,
   output logic [1:0]       res_code
);
   import sf_pkg::*;

   localparam int IDX_W = LEN_BITS + 1;
   localparam int HI_W  = LEN_BITS - 8;

   if (LEN_BITS < 9 || LEN_BITS > 16) begin : g_bad_len
      $error("LEN_BITS must lie in 9..16");
   end
   if (HDR_BYTES < 4 || HDR_BYTES > 16) begin : g_bad_hdr
      $error("HDR_BYTES must lie in 4..16");
   end

   st_e               st_q, st_d;
   logic [7:0]        skip_q, skip_d;
   logic [IDX_W-1:0]  idx_q;
   logic [HI_W-1:0]   len_hi_q;
   logic [LEN_BITS-1:0] len_q, len_now;
   logic              pkt_pusi_q, pusi_cur;
   logic              xfer, ptr_byte, in_body, start_ok, start_go, step, sec_last;
   logic              miss_now;
   logic [31:0]       crc_next;
   res_e              res_d, res_q;
   logic              res_fire;

   assign in_ready = !out_valid || out_ready;
   assign xfer     = in_valid && in_ready;
   assign ptr_byte = in_first && in_pusi;
   assign pusi_cur = in_first ? in_pusi : pkt_pusi_q;
   assign start_ok = !in_first && (in_data != STUFF_BYTE);
   assign start_go = (st_q == ST_START) && !ptr_byte && start_ok;
   assign in_body  = (st_q == ST_BODY) && !ptr_byte;
   assign step     = xfer && (start_go || in_body);
   assign len_now  = (idx_q == IDX_W'(2)) ? {len_hi_q, in_data} : len_q;
   assign sec_last = in_body && (idx_q >= IDX_W'(2)) &&
                     (idx_q == ({1'b0, len_now} + IDX_W'(2)));

   sf_crc_acc #(.POLY(CRC_POLY)) u_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (st_q == ST_START),
      .step     (step),
      .data     (in_data),
      .crc_next (crc_next)
   );

   sf_hdr_match #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (st_q == ST_START),
      .step      (step),
      .idx       (idx_q),
      .data      (in_data),
      .flt_value (flt_value),
      .flt_mask  (flt_mask),
      .miss_now  (miss_now)
   );

   always_comb begin
      st_d   = st_q;
      skip_d = skip_q;
      if (xfer) begin
         if (ptr_byte) begin
            if (in_data == 8'd0) st_d = ST_START;
            else begin
               st_d   = ST_SKIP;
               skip_d = in_data;
            end
         end else begin
            unique case (st_q)
               ST_SKIP: begin
                  skip_d = skip_q - 8'd1;
                  if (skip_q == 8'd1) st_d = ST_START;
               end
               ST_START: st_d = start_ok ? ST_BODY : ST_WAIT;
               ST_BODY:  if (sec_last) st_d = (cfg_multi && pusi_cur) ? ST_START : ST_WAIT;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      res_fire = xfer && ((ptr_byte && st_q == ST_BODY) || sec_last);
      if (ptr_byte)                                        res_d = RES_SHORT;
      else if (miss_now || idx_q < IDX_W'(HDR_BYTES - 1)) res_d = RES_MISS;
      else if (crc_next != 32'h0)                          res_d = RES_CRC;
      else                                                 res_d = RES_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_WAIT;
         skip_q     <= 8'd0;
         idx_q      <= '0;
         len_hi_q   <= '0;
         len_q      <= '0;
         pkt_pusi_q <= 1'b0;
         out_valid  <= 1'b0;
         out_data   <= 8'd0;
         out_first  <= 1'b0;
         out_last   <= 1'b0;
         res_valid  <= 1'b0;
         res_q      <= RES_OK;
      end else begin
         st_q      <= st_d;
         skip_q    <= skip_d;
         res_valid <= res_fire;
         if (res_fire) res_q <= res_d;
         if (xfer) begin
            if (in_first) pkt_pusi_q <= in_pusi;
            idx_q <= (step && !sec_last) ? idx_q + IDX_W'(1) : '0;
            if (in_body && idx_q == IDX_W'(1)) len_hi_q <= in_data[HI_W-1:0];
            if (in_body && idx_q == IDX_W'(2)) len_q    <= len_now;
            out_valid <= step;
            out_data  <= in_data;
            out_first <= start_go;
            out_last  <= sec_last;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   assign res_code = res_q;
endmodule

// File: rtl/sf_section_filter_chk.sv
module sf_section_filter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_ready,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_first,
   input logic       out_last,
   input logic       res_valid,
   input logic [1:0] res_code
);
   // R11
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                     $stable(out_first) && $stable(out_last)));

   // R11
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R3
   verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R3
   verdict_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code != 2'd3) |-> (out_valid && out_last));

   // R8
   short_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'd3) |-> !out_valid);

   // R10
   first_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_first) |-> !out_last);
endmodule

bind sf_section_filter sf_section_filter_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_first (out_first),
   .out_last  (out_last),
   .res_valid (res_valid),
   .res_code  (res_code)
);

// File: tb/tb_sf_section_filter.sv
`timescale 1ns/1ps
module tb_sf_section_filter;

   typedef struct packed {
      logic [7:0] d;
      logic       f;
      logic       p;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = 8'd0;
   logic        in_first = 1'b0;
   logic        in_pusi = 1'b0;
   logic        cfg_multi = 1'b0;
   logic [47:0] flt_value;
   logic [47:0] flt_mask;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;
   logic        out_first;
   logic        out_last;
   logic        res_valid;
   logic [1:0]  res_code;

   always #2.5 clk = ~clk;

   sf_section_filter dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_first(in_first), .in_pusi(in_pusi),
      .cfg_multi(cfg_multi), .flt_value(flt_value), .flt_mask(flt_mask),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_first(out_first), .out_last(out_last),
      .res_valid(res_valid), .res_code(res_code)
   );

   // filter lanes: lane0 = table id, lane1 = header byte 3 (R5)
   logic [7:0] fv [6];
   logic [7:0] fm [6];

   int    nchk = 0;
   int    nfail = 0;
   int    cyc = 0;
   bit    bp = 0;
   bit    done = 0;
   string cur_req = "R1";

   ent_t       stim_q [$];
   int         res_log [$];

   // reference model state
   int         m_mode = 0;    // 0 idle, 1 skipping, 2 expect start, 3 inside section
   int         m_skip = 0;
   bit         m_pusi = 0;
   logic [7:0] m_sec [$];

   bit         e_ov = 0;
   logic [7:0] e_od = 0;
   bit         e_of = 0;
   bit         e_ol = 0;
   bit         e_rv = 0;
   int         e_rc = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_of(logic [7:0] s[$]);
      logic [31:0] c = 32'hFFFF_FFFF;
      foreach (s[i]) begin
         for (int b = 7; b >= 0; b--) begin
            if (c[31] ^ s[i][b]) c = (c << 1) ^ 32'h04C11DB7;
            else                 c = c << 1;
         end
      end
      return c;
   endfunction

   function automatic int verdict(logic [7:0] s[$]);
      if (s.size() < 8) return 1;
      for (int k = 0; k < 8; k++) begin
         if (k == 1 || k == 2) continue;
         if (((s[k] ^ fv[k == 0 ? 0 : k - 2]) & fm[k == 0 ? 0 : k - 2]) != 8'h00) return 1;
      end
      if (crc_of(s) != 32'h0) return 2;
      return 0;
   endfunction

   task automatic model_step(ent_t e);
      e_ov = 0; e_of = 0; e_ol = 0; e_rv = 0; e_od = e.d;
      if (e.f) m_pusi = e.p;
      if (e.f && e.p) begin
         if (m_mode == 3) begin e_rv = 1; e_rc = 3; end
         m_sec.delete();
         if (e.d == 0) m_mode = 2;
         else begin m_mode = 1; m_skip = e.d; end
      end else if (m_mode == 1) begin
         m_skip--;
         if (m_skip == 0) m_mode = 2;
      end else if (m_mode == 2) begin
         if (e.f || e.d == 8'hFF) m_mode = 0;
         else begin
            m_sec.push_back(e.d);
            e_ov = 1; e_of = 1; m_mode = 3;
         end
      end else if (m_mode == 3) begin
         m_sec.push_back(e.d);
         e_ov = 1;
         if (m_sec.size() >= 3 &&
             m_sec.size() == ((int'(m_sec[1] & 8'h0F) << 8) + int'(m_sec[2]) + 3)) begin
            e_ol = 1; e_rv = 1;
            e_rc = verdict(m_sec);
            m_sec.delete();
            m_mode = (cfg_multi && m_pusi) ? 2 : 0;
         end
      end
   endtask

   task automatic cycle();
      bit exp_rdy;
      ent_t e;
      @(negedge clk);
      cyc++;
      chk(out_valid === e_ov, cur_req, "out_valid", out_valid, e_ov);
      if (e_ov) begin
         chk(out_data === e_od, cur_req, "out_data R10", out_data, e_od);
         chk(out_first === e_of, cur_req, "out_first R10", out_first, e_of);
         chk(out_last === e_ol, cur_req, "out_last R10", out_last, e_ol);
      end
      chk(res_valid === e_rv, cur_req, "res_valid R3", res_valid, e_rv);
      if (e_rv) chk(res_code === 2'(e_rc), cur_req, "res_code", res_code, e_rc);
      if (res_valid) res_log.push_back(int'(res_code));
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      if (stim_q.size() > 0) begin
         e = stim_q[0];
         in_valid = 1'b1; in_data = e.d; in_first = e.f; in_pusi = e.p;
      end else begin
         in_valid = 1'b0; in_first = 1'b0; in_pusi = 1'b0;
      end
      #0.5;
      exp_rdy = !e_ov || out_ready;
      chk(in_ready === exp_rdy, "R11", "in_ready", in_ready, exp_rdy);
      if (in_valid && exp_rdy) begin
         void'(stim_q.pop_front());
         model_step(e);
      end else begin
         if (out_ready) e_ov = 0;
         e_rv = 0;
      end
   endtask

   task automatic drain();
      while (stim_q.size() > 0) cycle();
      repeat (6) cycle();
   endtask

   task automatic mk_sec(ref logic [7:0] s[$], input logic [7:0] tid,
                         input logic [7:0] h3, input int pay_n, input bit bad);
      int len;
      logic [31:0] c;
      s.delete();
      len = pay_n + 4;
      s.push_back(tid);
      s.push_back(8'hB0 | 8'((len >> 8) & 15));
      s.push_back(8'(len & 255));
      for (int k = 0; k < pay_n; k++) s.push_back(k == 0 ? h3 : 8'(k * 7 + 1));
      c = crc_of(s);
      s.push_back(c[31:24]); s.push_back(c[23:16]);
      s.push_back(c[15:8]);  s.push_back(c[7:0]);
      if (bad) s[s.size() - 1] = s[s.size() - 1] ^ 8'h01;
   endtask

   task automatic add(ref logic [7:0] pk[$], input logic [7:0] s[$], input int from, input int to);
      for (int i = from; i < to; i++) pk.push_back(s[i]);
   endtask

   task automatic push_pkt(input logic [7:0] pk[$], input bit pusi);
      foreach (pk[i]) stim_q.push_back('{d: pk[i], f: (i == 0), p: pusi});
   endtask

   task automatic expect_res(string req, int n, int c0, int c1);
      chk(res_log.size() == n, req, "verdict count", res_log.size(), n);
      if (n > 0 && res_log.size() > 0) chk(res_log[0] == c0, req, "verdict 0", res_log[0], c0);
      if (n > 1 && res_log.size() > 1) chk(res_log[1] == c1, req, "verdict 1", res_log[1], c1);
      res_log.delete();
   endtask

   initial begin
      fv[0] = 8'h42; fm[0] = 8'hFF;
      fv[1] = 8'h10; fm[1] = 8'hF0;
      for (int i = 2; i < 6; i++) begin fv[i] = 8'h00; fm[i] = 8'h00; end
      for (int i = 0; i < 6; i++) begin
         flt_value[8*i +: 8] = fv[i];
         flt_mask[8*i +: 8]  = fm[i];
      end
   end

   initial begin
      logic [7:0] pk [$];
      logic [7:0] sa [$];
      logic [7:0] sb [$];
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(res_valid === 1'b0, "R1", "res_valid after reset", res_valid, 0);

      // R1: bytes before any payload-unit-start are ignored
      cur_req = "R1";
      mk_sec(sa, 8'h42, 8'h10, 6, 0);
      pk.delete(); add(pk, sa, 0, sa.size()); push_pkt(pk, 0);
      drain(); expect_res("R1", 0, 0, 0);

      // R2 R3 R10: pointer skip, good section, trailing stuffing
      cur_req = "R2";
      mk_sec(sa, 8'h42, 8'h10, 10, 0);
      pk = '{8'd2, 8'hAA, 8'hBB}; add(pk, sa, 0, sa.size());
      pk.push_back(8'hFF); pk.push_back(8'hFF); push_pkt(pk, 1);
      drain(); expect_res("R2", 1, 0, 0);

      // R7: corrupted CRC
      cur_req = "R7";
      mk_sec(sa, 8'h42, 8'h12, 9, 1);
      pk = '{8'd0}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R7", 1, 2, 0);

      // R5: table id mismatch
      cur_req = "R5";
      mk_sec(sa, 8'h43, 8'h10, 8, 0);
      pk = '{8'd0}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R5", 1, 1, 0);

      // R7: miss wins over bad CRC
      cur_req = "R7";
      mk_sec(sa, 8'h42, 8'h25, 8, 1);
      pk = '{8'd0}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R7", 1, 1, 0);

      // R6: section shorter than the filter window, valid CRC
      cur_req = "R6";
      mk_sec(sa, 8'h42, 8'h10, 0, 0);
      pk = '{8'd0}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R6", 1, 1, 0);

      // R4: section split over two packets, header cut too
      cur_req = "R4";
      mk_sec(sa, 8'h42, 8'h1C, 30, 0);
      pk = '{8'd0}; add(pk, sa, 0, 2); push_pkt(pk, 1);
      pk.delete(); add(pk, sa, 2, 14); push_pkt(pk, 0);
      pk.delete(); add(pk, sa, 14, sa.size()); pk.push_back(8'hFF); push_pkt(pk, 0);
      drain(); expect_res("R4", 1, 0, 0);

      // R8: partial section cut by a new pointer, restart at offset
      cur_req = "R8";
      mk_sec(sa, 8'h42, 8'h10, 20, 0);
      mk_sec(sb, 8'h42, 8'h13, 5, 0);
      pk = '{8'd0}; add(pk, sa, 0, 10); push_pkt(pk, 1);
      pk = '{8'd3, 8'h01, 8'h02, 8'h03}; add(pk, sb, 0, sb.size()); push_pkt(pk, 1);
      drain(); expect_res("R8", 2, 3, 0);

      // R9: two sections in one packet with multi enabled
      cur_req = "R9";
      cfg_multi = 1'b1;
      mk_sec(sa, 8'h42, 8'h10, 6, 0);
      mk_sec(sb, 8'h42, 8'h11, 7, 1);
      pk = '{8'd0}; add(pk, sa, 0, sa.size()); add(pk, sb, 0, sb.size());
      pk.push_back(8'hFF); push_pkt(pk, 1);
      drain(); expect_res("R9", 2, 0, 2);

      // R9: same packet with multi disabled: second section ignored
      cfg_multi = 1'b0;
      push_pkt(pk, 1);
      drain(); expect_res("R9", 1, 0, 0);

      // R9: section ends in a packet without payload-unit-start
      cfg_multi = 1'b1;
      pk = '{8'd0}; add(pk, sa, 0, 5); push_pkt(pk, 1);
      pk.delete(); add(pk, sa, 5, sa.size()); add(pk, sb, 0, sb.size()); push_pkt(pk, 0);
      drain(); expect_res("R9", 1, 0, 0);

      // R9: stuffing at a section start ends the packet
      pk = '{8'd0, 8'hFF}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R9", 0, 0, 0);
      cfg_multi = 1'b0;

      // R11: output backpressure
      cur_req = "R11";
      bp = 1;
      mk_sec(sa, 8'h42, 8'h10, 12, 0);
      pk = '{8'd1, 8'h55}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R11", 1, 0, 0);
      bp = 0;

      // R5: masked-off bits have no effect
      cur_req = "R5";
      mk_sec(sa, 8'h42, 8'h17, 6, 0);
      pk = '{8'd0}; add(pk, sa, 0, sa.size()); push_pkt(pk, 1);
      drain(); expect_res("R5", 1, 0, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #750000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule